// File: doc/BRIEF.md
# Integer Adder-Subtractor with Status Flags

This unit performs the integer add, add-with-carry and subtract operations of a small RISC pipeline stage. An operation is issued with two operands, an operation select, an optional sign-extended immediate in place of the second operand, and the current status word. One clock later it presents four things: the result, the status word with its carry and overflow bits rewritten, a range-exception request, and a write-enable qualifier for the destination register.

Carry and overflow are both written on every arithmetic operation. Each is cleared when its condition does not occur, and all other status bits pass through unchanged. The exception request is raised when either flag comes out set while the overflow-trap enable bit of the incoming status word is on. In that case the result is still driven, but the write-enable qualifier is withheld so the pipeline can drop the writeback. Operand values are always used exactly as given, whatever register they came from.

Top module: `arith_flag_unit`

## Requirements
- R1: After reset, result, statusOut, rangeReq, writeValid and outValid are all zero.
- R2: With opSel=00 (add), result is (A+B) modulo 2^DATA_W. The status carry bit (position CY_POS, default 10) is the unsigned carry out of the top bit. Outputs appear after the first rising edge following the issue.
- R3: For add, the overflow bit (position OV_POS, default 11) is set exactly when A and B have equal signs and the result sign differs from them.
- R4: With opSel=01 (add-with-carry), the incoming status carry bit is added as carry-in. Carry and overflow are correct when the carry-in alone causes the wrap: all-ones + 0 + 1 gives result 0 with carry 1.
- R5: With opSel=10 (subtract), result is (A-B) modulo 2^DATA_W, carry is set exactly when A < B unsigned, and overflow is set exactly when the signed difference is out of range.
- R6: Carry and overflow are cleared when their condition is absent, and every other status bit is copied from statusIn.
- R7: rangeReq is 1 exactly when an arithmetic operation leaves carry or overflow set while statusIn bit OVE_POS (default 12) is 1.
- R8: When rangeReq is 1, writeValid is 0 and result still holds the computed value. For an arithmetic operation without a request, writeValid is 1.
- R9: With useImm=1, operand B is imm sign-extended to DATA_W bits, the same flag rules apply, and opB has no effect.
- R10: opSel=11 is a no-operation: outValid is 1, statusOut equals statusIn, result is 0, and rangeReq and writeValid are 0.
- R11: A cycle with issueValid=0 gives outValid, writeValid and rangeReq of 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 no-operation |
| useImm | input | 1 | Replace opB with the sign-extended immediate |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| imm | input | IMM_W | Immediate operand |
| statusIn | input | SR_W | Current status word |
| result | output | DATA_W | Registered arithmetic result |
| statusOut | output | SR_W | Registered next status word |
| rangeReq | output | 1 | Range-exception request |
| writeValid | output | 1 | Destination write may proceed |
| outValid | output | 1 | Outputs belong to an issued operation |

## Verification
The assertions assume that issueValid, opSel, useImm, the operands and statusIn are stable and known around each rising edge. They also assume that the status bit positions are distinct and lie inside the status word. The bench drives every input on the falling edge and holds it through the next rising edge. It keeps to a narrow configuration (6-bit data, 4-bit immediate) whose bit positions match the defaults. It sweeps every operand pair for each operation and carry-in, so each input combination the assertions reason about is actually reached.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADDC = 2'b01,
    OP_SUB  = 2'b10,
    OP_NONE = 2'b11
  } afuOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic subMode;
    logic carryIn;
    logic useImm;
    logic writeFlags;
  } afuStrobe_t;

endpackage

// File: rtl/afu_ctrl.sv
module afu_ctrl
  import afu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic [1:0] opSel,
  input  logic       useImm,
  input  logic       ovEnable,
  input  logic       carryFlag,
  input  logic       ovFlag,
  output afuStrobe_t strobe,
  output logic       outValid,
  output logic       rangeReq,
  output logic       writeValid
);

  logic reqNow;

  always_comb begin
    strobe        = '0;
    strobe.issue  = issueValid;
    strobe.useImm = useImm;
    unique case (afuOp_e'(opSel))
      OP_ADD:  strobe.writeFlags = 1'b1;
      OP_ADDC: begin
        strobe.writeFlags = 1'b1;
        strobe.carryIn    = 1'b1;
      end
      OP_SUB: begin
        strobe.writeFlags = 1'b1;
        strobe.subMode    = 1'b1;
      end
      default: strobe.writeFlags = 1'b0;
    endcase
  end

  assign reqNow = issueValid & strobe.writeFlags & (carryFlag | ovFlag) & ovEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      rangeReq   <= 1'b0;
      writeValid <= 1'b0;
    end else begin
      outValid   <= issueValid;
      rangeReq   <= reqNow;
      writeValid <= issueValid & strobe.writeFlags & ~reqNow;
    end
  end

  // R8: writeback qualifier never coexists with an exception request
  a_r8_wb_blocked: assert property (@(posedge clk) disable iff (!rstN)
    writeValid |-> (outValid && !rangeReq));

  // R11: an idle cycle yields no valid, write or request
  a_r11_idle: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!outValid && !writeValid && !rangeReq));

  // R10: no-operation raises nothing
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && opSel == 2'b11) |=> (outValid && !rangeReq && !writeValid));

  // R7: a request only accompanies a valid output
  a_r7_req_valid: assert property (@(posedge clk) disable iff (!rstN)
    rangeReq |-> outValid);

endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SR_W   = 32,
  parameter int CY_POS = 10,
  parameter int OV_POS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  afuStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SR_W-1:0]   statusIn,
  output logic              carryFlag,
  output logic              ovFlag,
  output logic [DATA_W-1:0] result,
  output logic [SR_W-1:0]   statusOut
);

  localparam int MSB = DATA_W - 1;
  localparam logic [SR_W-1:0] FLAG_MASK =
    (SR_W'(1) << CY_POS) | (SR_W'(1) << OV_POS);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] bSel;
  logic [DATA_W-1:0] bAdd;
  logic              cin;
  logic              cout;
  logic [DATA_W-1:0] sumRaw;
  logic [SR_W-1:0]   nextStatus;

  generate
    if (IMM_W < DATA_W) begin : g_sext
      assign immExt = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign immExt = imm[DATA_W-1:0];
    end
  endgenerate

  assign bSel = strobe.useImm ? immExt : opB;
  assign bAdd = strobe.subMode ? ~bSel : bSel;
  assign cin  = strobe.subMode | (strobe.carryIn & statusIn[CY_POS]);

  // single shared adder; subtract is A + ~B + 1
  assign {cout, sumRaw} = {1'b0, opA} + {1'b0, bAdd} + {{DATA_W{1'b0}}, cin};

  assign carryFlag = strobe.subMode ? ~cout : cout;
  assign ovFlag    = ~(opA[MSB] ^ bAdd[MSB]) & (opA[MSB] ^ sumRaw[MSB]);

  always_comb begin
    nextStatus = statusIn;
    if (strobe.writeFlags) begin
      nextStatus[CY_POS] = carryFlag;
      nextStatus[OV_POS] = ovFlag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      statusOut <= '0;
    end else if (strobe.issue) begin
      result    <= strobe.writeFlags ? sumRaw : '0;
      statusOut <= nextStatus;
    end
  end

  // R6: bits other than carry and overflow copy through
  a_r6_passthru: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> ((statusOut & ~FLAG_MASK) == ($past(statusIn) & ~FLAG_MASK)));

  // R5: register-register subtract borrow equals unsigned less-than
  a_r5_borrow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.subMode && !strobe.useImm)
      |=> (statusOut[CY_POS] == ($past(opA) < $past(opB))));

  // R10: no-operation leaves the status word and zeroes the result
  a_r10_nop_status: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !strobe.writeFlags)
      |=> (statusOut == $past(statusIn) && result == '0));

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SR_W    = 32,
  parameter int CY_POS  = 10,
  parameter int OV_POS  = 11,
  parameter int OVE_POS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        opSel,
  input  logic              useImm,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SR_W-1:0]   statusIn,
  output logic [DATA_W-1:0] result,
  output logic [SR_W-1:0]   statusOut,
  output logic              rangeReq,
  output logic              writeValid,
  output logic              outValid
);

  afuStrobe_t strobe;
  logic       carryFlag;
  logic       ovFlag;

  afu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .opSel      (opSel),
    .useImm     (useImm),
    .ovEnable   (statusIn[OVE_POS]),
    .carryFlag  (carryFlag),
    .ovFlag     (ovFlag),
    .strobe     (strobe),
    .outValid   (outValid),
    .rangeReq   (rangeReq),
    .writeValid (writeValid)
  );

  afu_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SR_W   (SR_W),
    .CY_POS (CY_POS),
    .OV_POS (OV_POS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .imm       (imm),
    .statusIn  (statusIn),
    .carryFlag (carryFlag),
    .ovFlag    (ovFlag),
    .result    (result),
    .statusOut (statusOut)
  );

  // R7: a request implies a set flag and an enabled trap in the written status
  a_r7_req_flags: assert property (@(posedge clk) disable iff (!rstN)
    rangeReq |-> ((statusOut[CY_POS] || statusOut[OV_POS]) && statusOut[OVE_POS]));

endmodule

// File: tb/arith_flag_unit_bench.sv
`timescale 1ns/1ps
module arith_flag_unit_bench;

  localparam int DW = 6;
  localparam int IW = 4;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [1:0]    opSel = 2'b00;
  logic          useImm = 1'b0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic [IW-1:0] imm = '0;
  logic [SW-1:0] statusIn = '0;
  logic [DW-1:0] result;
  logic [SW-1:0] statusOut;
  logic          rangeReq;
  logic          writeValid;
  logic          outValid;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  arith_flag_unit #(
    .DATA_W(DW), .IMM_W(IW), .SR_W(SW), .CY_POS(10), .OV_POS(11), .OVE_POS(12)
  ) u_arith_flag_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .opSel(opSel),
    .useImm(useImm), .opA(opA), .opB(opB), .imm(imm), .statusIn(statusIn),
    .result(result), .statusOut(statusOut), .rangeReq(rangeReq),
    .writeValid(writeValid), .outValid(outValid)
  );

  function automatic int sval(input int v);
    return (v >= 32) ? v - 64 : v;
  endfunction

  // status word: fixed junk bits, carry-in, stale overflow, trap enable
  function automatic logic [SW-1:0] mkStatus(input int cy, input int ov, input int ove);
    return (SW'(16'hA0A5) & ~SW'(16'h1C00)) | SW'(cy << 10) | SW'(ov << 11) | SW'(ove << 12);
  endfunction

  task automatic step(input string tag, input bit iss, input int op, input bit im,
                      input int a, input int b, input int iv, input logic [SW-1:0] st);
    int bEff, s, ss, res, cy, ov, req, wv;
    logic [SW-1:0] expSt;
    logic [DW+SW+2:0] exp, got;
    bEff = im ? ((iv >= 8) ? iv + 48 : iv) : b;
    res = 0; cy = 0; ov = 0;
    if (op == 0 || op == 1) begin
      s = a + bEff + ((op == 1) ? int'(st[10]) : 0);
      ss = sval(a) + sval(bEff) + ((op == 1) ? int'(st[10]) : 0);
      res = s & 63; cy = (s >> 6) & 1; ov = (ss > 31 || ss < -32) ? 1 : 0;
    end else if (op == 2) begin
      s = a - bEff;
      ss = sval(a) - sval(bEff);
      res = s & 63; cy = (a < bEff) ? 1 : 0; ov = (ss > 31 || ss < -32) ? 1 : 0;
    end
    expSt = st;
    if (op != 3) begin
      expSt[10] = cy[0];
      expSt[11] = ov[0];
    end
    req = (op != 3 && (cy | ov) != 0 && st[12]) ? 1 : 0;
    wv  = (op != 3 && req == 0) ? 1 : 0;
    @(negedge clk);
    issueValid = iss; opSel = op[1:0]; useImm = im;
    opA = a[DW-1:0]; opB = b[DW-1:0]; imm = iv[IW-1:0]; statusIn = st;
    @(negedge clk);
    total++;
    if (iss) begin
      exp = {res[DW-1:0], expSt, req[0], wv[0], 1'b1};
      got = {result, statusOut, rangeReq, writeValid, outValid};
    end else begin
      exp = '0;
      got = {{(DW+SW){1'b0}}, rangeReq, writeValid, outValid};
    end
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d imm=%0d actual=%h expected=%h",
               tag, op, a, b, iv, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if ({result, statusOut, rangeReq, writeValid, outValid} !== '0) begin
      bad++;
      $display("FAIL R1 reset actual=%h expected=0",
               {result, statusOut, rangeReq, writeValid, outValid});
    end

    // directed corners
    step("R4 carry-in wrap", 1, 1, 0, 63, 0, 0, mkStatus(1, 0, 0));
    step("R3 add overflow", 1, 0, 0, 31, 1, 0, mkStatus(0, 0, 0));
    step("R2 add carry", 1, 0, 0, 63, 1, 0, mkStatus(0, 0, 0));
    step("R5 sub borrow", 1, 2, 0, 0, 1, 0, mkStatus(0, 0, 0));
    step("R5 sub overflow", 1, 2, 0, 32, 1, 0, mkStatus(0, 0, 0));
    step("R6 flags cleared", 1, 0, 0, 1, 1, 0, mkStatus(1, 1, 1));
    step("R7 R8 request blocks write", 1, 0, 0, 31, 1, 0, mkStatus(0, 0, 1));
    step("R7 enable off", 1, 2, 0, 0, 1, 0, mkStatus(0, 0, 0));
    step("R9 negative imm", 1, 0, 1, 5, 63, 15, mkStatus(0, 0, 1));
    step("R10 nop", 1, 3, 0, 63, 63, 0, mkStatus(1, 1, 1));
    step("R10 nop plain", 1, 3, 1, 12, 9, 7, mkStatus(0, 1, 0));
    step("R11 idle", 0, 0, 0, 31, 1, 0, mkStatus(0, 0, 1));
    step("R11 idle after nop", 0, 2, 0, 0, 1, 0, mkStatus(0, 0, 1));

    // full operand sweeps
    for (int op = 0; op < 3; op++) begin
      for (int c = 0; c < 2; c++) begin
        if (op != 1 && c == 1) continue;
        for (int a = 0; a < 64; a++) begin
          for (int b = 0; b < 64; b++) begin
            step((op == 0) ? "R2 R3 R6 R7 R8 add" :
                 (op == 1) ? "R4 R6 R7 R8 addc" : "R5 R6 R7 R8 sub",
                 1, op, 0, a, b, 0, mkStatus(c, (a >> 1) & 1, (a ^ b) & 1));
          end
        end
      end
    end

    // immediate sweep, opB driven with junk
    for (int op = 0; op < 2; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 64; a++) begin
          for (int iv = 0; iv < 16; iv++) begin
            step("R9 imm", 1, op, 1, a, (~a) & 63, iv, mkStatus(c, 0, iv & 1));
          end
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule